// File: doc/BRIEF.md
# Home-Node Directory Controller

This block is the home side of a directory-based coherence scheme for a distributed shared memory machine. For every memory block it owns, it keeps a directory entry: a coherence state (Invalid, Shared or Exclusive) and a sharer vector with one bit per node. Requesting nodes send it read or read-exclusive requests. For each request the controller does one of three things. It returns the line from its own memory. It forwards the request to the remote node that holds the block exclusively, and that node then replies straight to the requester. Or it invalidates the other cached copies while it grants exclusivity.

The controller handles one request at a time, using a valid/ready handshake on the request side. Outbound traffic leaves on a two-lane message port that has one shared ready. Lane 0 carries data replies. Lane 1 carries forwards and invalidations. This lets an exclusive data reply leave in the same cycle as the first invalidation. The grant does not wait for acknowledgements, which suits a relaxed consistency model with explicit synchronization. Memory is read through a synchronous port that has one cycle of latency.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1, msg_valid_o is 0 and mem_rd_en_o is 0. Every directory entry is Invalid with no sharers, so the first read of any block is answered from memory.
- R2: A read of a block that is not Exclusive at another node produces exactly one DATA_REPLY. It appears on lane 0, with type 2'b00 in msg_type_o[1:0], destination msg_dst_o[NID_W-1:0] equal to the requester, and msg_data_o equal to the memory line at that address.
- R3: A read of a block held Exclusive by a different node produces one FORWARD (type 2'b01 on lane 1, msg_type_o[3:2]) addressed to the owner. It issues no memory read and no data reply.
- R4: After a forwarded read, the entry is Shared and has both the former owner and the requester as sharers. A later exclusive request from a third node invalidates both.
- R5: An exclusive request sends an INVALIDATE (type 2'b10 on lane 1, destination in msg_dst_o[2*NID_W-1:NID_W]) to every sharer except the requester. The invalidations go out one per accepted handshake in ascending node-id order. The entry then becomes Exclusive with only the requester as sharer.
- R6: The data reply to an exclusive request is valid in the same cycle as the first invalidate. No acknowledgement is awaited.
- R7: An exclusive request from the node that already holds the block Exclusive yields only a DATA_REPLY to that node, with no lane 1 message.
- R8: A read grant adds the requester to the sharers and keeps the existing sharers.
- R9: Once a request is accepted, req_ready_o stays 0 until every outbound message for that request has been handshaked.
- R10: While any msg_valid_o bit is 1 and msg_ready_i is 0, all msg_* outputs hold their values.
- R11: mem_rd_en_o is 1, with mem_rd_addr_o equal to the request address, in the accept cycle of every request that needs a data reply, and 0 for a forwarded read. No message is valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request accepted on valid & ready |
| req_excl_i | input | 1 | 1 = read-exclusive, 0 = read |
| req_src_i | input | NID_W | Requesting node id |
| req_addr_i | input | ADDR_W | Block address (also directory index) |
| mem_rd_en_o | output | 1 | Memory read strobe |
| mem_rd_addr_o | output | ADDR_W | Memory read address |
| mem_rd_data_i | input | LINE_W | Line data, valid the cycle after the strobe |
| msg_valid_o | output | 2 | Lane valids: bit 0 reply lane, bit 1 coherence lane |
| msg_ready_i | input | 1 | Shared ready for both lanes |
| msg_type_o | output | 4 | {lane 1 type, lane 0 type} |
| msg_dst_o | output | 2*NID_W | {lane 1 destination, lane 0 destination} |
| msg_addr_o | output | ADDR_W | Block address of the messages |
| msg_data_o | output | LINE_W | Line carried by a data reply |

## Verification
The bench builds the block with four nodes, a 3-bit address (eight directory entries) and a 32-bit line. With only eight blocks and four nodes, random traffic keeps hitting the same entries. It therefore reaches forwarded reads, invalidation bursts to one, two or three sharers, and repeat exclusive requests by the owner, all within a few hundred requests. The outbound ready is withheld at random, so stalls fall both between invalidations and on the cycle that pairs the reply with the first invalidation.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2
  } coh_e;

  typedef enum logic [1:0] {
    MSG_DATA = 2'b00,
    MSG_FWD  = 2'b01,
    MSG_INV  = 2'b10
  } msg_e;
endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_idx_i,
  output coh_e              rd_state_o,
  output logic [NODES-1:0]  rd_sh_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_idx_i,
  input  coh_e              wr_state_i,
  input  logic [NODES-1:0]  wr_sh_i
);
  localparam int BLOCKS = 1 << ADDR_W;

  coh_e             st_q [BLOCKS];
  logic [NODES-1:0] sh_q [BLOCKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BLOCKS; i++) begin
        st_q[i] <= ST_I;
        sh_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      st_q[wr_idx_i] <= wr_state_i;
      sh_q[wr_idx_i] <= wr_sh_i;
    end
  end

  assign rd_state_o = st_q[rd_idx_i];
  assign rd_sh_o    = sh_q[rd_idx_i];

  a_r5_excl_one_holder: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_state_i == ST_E) |-> ($countones(wr_sh_i) == 1));
  a_r8_read_keeps_sharers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_state_i == ST_S) |-> ((wr_sh_i & sh_q[wr_idx_i]) == sh_q[wr_idx_i]));
endmodule

// File: rtl/dir_policy.sv
module dir_policy
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int NID_W = 2
) (
  input  logic             excl_i,
  input  logic [NID_W-1:0] src_i,
  input  coh_e             state_i,
  input  logic [NODES-1:0] sh_i,
  output coh_e             nxt_state_o,
  output logic [NODES-1:0] nxt_sh_o,
  output logic             need_data_o,
  output logic             fwd_o,
  output logic [NID_W-1:0] fwd_dst_o,
  output logic [NODES-1:0] inv_o
);
  logic [NODES-1:0] self_bit;
  logic             remote_owner;

  assign self_bit     = NODES'(1) << src_i;
  assign remote_owner = (state_i == ST_E) && (sh_i != self_bit);

  always_comb begin
    fwd_dst_o = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (sh_i[i]) fwd_dst_o = NID_W'(i);
    end
  end

  always_comb begin
    if (excl_i) begin
      nxt_state_o = ST_E;
      nxt_sh_o    = self_bit;
      need_data_o = 1'b1;
      fwd_o       = 1'b0;
      inv_o       = sh_i & ~self_bit;
    end else begin
      nxt_state_o = ST_S;
      nxt_sh_o    = sh_i | self_bit;
      need_data_o = !remote_owner;
      fwd_o       = remote_owner;
      inv_o       = '0;
    end
  end
endmodule

// File: rtl/dir_issue.sv
module dir_issue
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int NID_W  = 2,
  parameter int ADDR_W = 3,
  parameter int LINE_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 accept_i,
  input  logic                 need_data_i,
  input  logic                 fwd_i,
  input  logic [NID_W-1:0]     fwd_dst_i,
  input  logic [NODES-1:0]     inv_i,
  input  logic [NID_W-1:0]     src_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [LINE_W-1:0]    mem_data_i,
  input  logic                 msg_ready_i,
  output logic                 busy_o,
  output logic [1:0]           msg_valid_o,
  output logic [3:0]           msg_type_o,
  output logic [2*NID_W-1:0]   msg_dst_o,
  output logic [ADDR_W-1:0]    msg_addr_o,
  output logic [LINE_W-1:0]    msg_data_o
);
  typedef enum logic [1:0] {PH_IDLE, PH_FETCH, PH_SEND} phase_e;

  phase_e            phase_q;
  logic              rpl_q, fwd_q;
  logic [NODES-1:0]  inv_q, inv_low, inv_rest;
  logic [NID_W-1:0]  fdst_q, src_q, inv_idx;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] line_q;
  msg_e              lane1_type;

  assign inv_low  = inv_q & (~inv_q + NODES'(1));
  assign inv_rest = inv_q & ~inv_low;

  always_comb begin
    inv_idx = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (inv_q[i]) inv_idx = NID_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      rpl_q   <= 1'b0;
      fwd_q   <= 1'b0;
      inv_q   <= '0;
      fdst_q  <= '0;
      src_q   <= '0;
      addr_q  <= '0;
      line_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (accept_i) begin
          rpl_q   <= need_data_i;
          fwd_q   <= fwd_i;
          fdst_q  <= fwd_dst_i;
          inv_q   <= inv_i;
          src_q   <= src_i;
          addr_q  <= addr_i;
          phase_q <= need_data_i ? PH_FETCH : PH_SEND;
        end
        PH_FETCH: begin
          line_q  <= mem_data_i;
          phase_q <= PH_SEND;
        end
        PH_SEND: if (msg_ready_i) begin
          rpl_q <= 1'b0;
          fwd_q <= 1'b0;
          inv_q <= inv_rest;
          if (inv_rest == '0) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // lane 0: data reply, paired with first invalidate; lane 1: forward or invalidate
  assign lane1_type     = fwd_q ? MSG_FWD : MSG_INV;
  assign busy_o         = (phase_q != PH_IDLE);
  assign msg_valid_o[0] = (phase_q == PH_SEND) && rpl_q;
  assign msg_valid_o[1] = (phase_q == PH_SEND) && (fwd_q || (inv_q != '0));
  assign msg_type_o     = {lane1_type, MSG_DATA};
  assign msg_dst_o      = {(fwd_q ? fdst_q : inv_idx), src_q};
  assign msg_addr_o     = addr_q;
  assign msg_data_o     = line_q;

  a_r10_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((msg_valid_o != 2'b00) && !msg_ready_i) |=>
      ($stable(msg_valid_o) && $stable(msg_type_o) && $stable(msg_dst_o) &&
       $stable(msg_addr_o) && $stable(msg_data_o)));
  a_r6_reply_with_first_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o[1] && msg_type_o[3:2] == 2'(MSG_INV) && msg_ready_i) |=> !msg_valid_o[0]);
  a_r3_forward_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o[1] && msg_type_o[3:2] == 2'(MSG_FWD)) |-> !msg_valid_o[0]);
  a_r5_no_self_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o[1] && msg_type_o[3:2] == 2'(MSG_INV)) |->
      (msg_dst_o[2*NID_W-1:NID_W] != msg_dst_o[NID_W-1:0]));
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int ADDR_W = 3,
  parameter int LINE_W = 32,
  localparam int NID_W = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_excl_i,
  input  logic [NID_W-1:0]   req_src_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  output logic               mem_rd_en_o,
  output logic [ADDR_W-1:0]  mem_rd_addr_o,
  input  logic [LINE_W-1:0]  mem_rd_data_i,
  output logic [1:0]         msg_valid_o,
  input  logic               msg_ready_i,
  output logic [3:0]         msg_type_o,
  output logic [2*NID_W-1:0] msg_dst_o,
  output logic [ADDR_W-1:0]  msg_addr_o,
  output logic [LINE_W-1:0]  msg_data_o
);
  coh_e             cur_state, nxt_state;
  logic [NODES-1:0] cur_sh, nxt_sh, inv_vec;
  logic             need_data, fwd, busy, accept;
  logic [NID_W-1:0] fwd_dst;

  assign req_ready_o   = !busy;
  assign accept        = req_valid_i && req_ready_o;
  assign mem_rd_en_o   = accept && need_data;
  assign mem_rd_addr_o = req_addr_i;

  dir_store #(.NODES(NODES), .ADDR_W(ADDR_W)) i_store (
    .clk_i, .rst_ni,
    .rd_idx_i   (req_addr_i),
    .rd_state_o (cur_state),
    .rd_sh_o    (cur_sh),
    .wr_en_i    (accept),
    .wr_idx_i   (req_addr_i),
    .wr_state_i (nxt_state),
    .wr_sh_i    (nxt_sh)
  );

  dir_policy #(.NODES(NODES), .NID_W(NID_W)) i_policy (
    .excl_i      (req_excl_i),
    .src_i       (req_src_i),
    .state_i     (cur_state),
    .sh_i        (cur_sh),
    .nxt_state_o (nxt_state),
    .nxt_sh_o    (nxt_sh),
    .need_data_o (need_data),
    .fwd_o       (fwd),
    .fwd_dst_o   (fwd_dst),
    .inv_o       (inv_vec)
  );

  dir_issue #(.NODES(NODES), .NID_W(NID_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) i_issue (
    .clk_i, .rst_ni,
    .accept_i    (accept),
    .need_data_i (need_data),
    .fwd_i       (fwd),
    .fwd_dst_i   (fwd_dst),
    .inv_i       (inv_vec),
    .src_i       (req_src_i),
    .addr_i      (req_addr_i),
    .mem_data_i  (mem_rd_data_i),
    .msg_ready_i,
    .busy_o      (busy),
    .msg_valid_o,
    .msg_type_o,
    .msg_dst_o,
    .msg_addr_o,
    .msg_data_o
  );

  a_r9_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r11_no_msg_while_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_en_o |=> (msg_valid_o == 2'b00));
endmodule

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
  localparam int NODES = 4, ADDR_W = 3, LINE_W = 32, NID_W = 2;

  logic               clk = 1'b0, rst_ni = 1'b0;
  logic               req_valid_i = 1'b0, req_excl_i = 1'b0, msg_ready_i = 1'b0;
  logic [NID_W-1:0]   req_src_i = '0;
  logic [ADDR_W-1:0]  req_addr_i = '0;
  logic               req_ready_o, mem_rd_en_o;
  logic [ADDR_W-1:0]  mem_rd_addr_o, msg_addr_o;
  logic [LINE_W-1:0]  mem_rd_data_i = '0, msg_data_o;
  logic [1:0]         msg_valid_o;
  logic [3:0]         msg_type_o;
  logic [2*NID_W-1:0] msg_dst_o;

  int n_chk = 0, n_fail = 0;
  int m_st [8];
  logic [3:0] m_sh [8];

  always #2 clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) i_dir_home_ctrl (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_ready_o, .req_excl_i, .req_src_i, .req_addr_i,
    .mem_rd_en_o, .mem_rd_addr_o, .mem_rd_data_i, .msg_valid_o, .msg_ready_i,
    .msg_type_o, .msg_dst_o, .msg_addr_o, .msg_data_o
  );

  function automatic logic [LINE_W-1:0] mem_val(input int a);
    return 32'hC0DE_0000 ^ (32'(a) * 32'h0101_0111);
  endfunction

  always @(posedge clk) if (mem_rd_en_o) mem_rd_data_i <= mem_val(int'(mem_rd_addr_o));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  task automatic do_req(input bit excl, input int src, input int addr, input string tag);
    logic [3:0] self = 4'b1 << src;
    logic [3:0] sh = m_sh[addr];
    int st = m_st[addr];
    bit exp_rpl = 1'b1;
    int exp_n = 0, got = 0, cyc = 0, owner = 0;
    int exp_ty [4], exp_dst [4];
    bit rpl_got = 0, stall = 0, rdy;
    logic [1:0] p_v; logic [3:0] p_t; logic [2*NID_W-1:0] p_d; logic [LINE_W-1:0] p_dat;
    for (int i = 3; i >= 0; i--) if (sh[i]) owner = i;
    if (!excl) begin
      if (st == 2 && sh != self) begin
        exp_rpl = 0; exp_ty[0] = 1; exp_dst[0] = owner; exp_n = 1;
      end
      m_st[addr] = 1; m_sh[addr] = sh | self;
    end else begin
      for (int i = 0; i < 4; i++) if (sh[i] && i != src) begin
        exp_ty[exp_n] = 2; exp_dst[exp_n] = i; exp_n++;
      end
      m_st[addr] = 2; m_sh[addr] = self;
    end
    @(negedge clk);
    chk(req_ready_o == 1'b1, {tag, " R9 idle before request"}, req_ready_o, 1);
    req_valid_i = 1'b1; req_excl_i = excl; req_src_i = NID_W'(src); req_addr_i = ADDR_W'(addr);
    #1;
    chk(mem_rd_en_o == exp_rpl && (!exp_rpl || mem_rd_addr_o == ADDR_W'(addr)),
        {tag, " R11 memory read strobe"}, {mem_rd_en_o, mem_rd_addr_o}, {exp_rpl, ADDR_W'(addr)});
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    while (!req_ready_o && cyc < 64) begin
      rdy = ($urandom % 4) != 0;
      msg_ready_i = rdy;
      #1;
      if (stall)
        chk(msg_valid_o == p_v && msg_type_o == p_t && msg_dst_o == p_d && msg_data_o == p_dat,
            {tag, " R10 hold on stall"}, {msg_valid_o, msg_dst_o}, {p_v, p_d});
      if (msg_valid_o != 0) chk(msg_addr_o == ADDR_W'(addr), {tag, " R2 message address"}, msg_addr_o, addr);
      if (rdy && msg_valid_o[0]) begin
        chk(exp_rpl && !rpl_got, {tag, (excl && exp_n == 0 && st == 2) ? " R7" : " R2", " reply expected"},
            rpl_got, 0);
        chk(msg_type_o[1:0] == 2'b00 && msg_dst_o[1:0] == 2'(src) && msg_data_o == mem_val(addr),
            {tag, " R2 reply contents"}, {msg_type_o[1:0], msg_dst_o[1:0], msg_data_o},
            {2'b00, 2'(src), mem_val(addr)});
        if (excl && exp_n > 0)
          chk(msg_valid_o[1] && got == 0, {tag, " R6 reply with first invalidate"}, msg_valid_o, 2'b11);
        rpl_got = 1;
      end
      if (rdy && msg_valid_o[1]) begin
        if (got < exp_n) begin
          chk(int'(msg_type_o[3:2]) == exp_ty[got] && int'(msg_dst_o[3:2]) == exp_dst[got],
              {tag, exp_ty[got] == 1 ? " R3 forward" : " R5 invalidate order"},
              {msg_type_o[3:2], msg_dst_o[3:2]}, {2'(exp_ty[got]), 2'(exp_dst[got])});
        end else begin
          chk(1'b0, {tag, " R7 unexpected lane 1 message"}, msg_dst_o[3:2], 0);
        end
        got++;
      end
      stall = !rdy && (msg_valid_o != 0);
      p_v = msg_valid_o; p_t = msg_type_o; p_d = msg_dst_o; p_dat = msg_data_o;
      @(negedge clk);
      cyc++;
    end
    chk(rpl_got == exp_rpl && got == exp_n, {tag, " R9 all messages before ready"},
        {rpl_got, 8'(got)}, {exp_rpl, 8'(exp_n)});
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_sh[i] = '0; end
    #1;
    chk(req_ready_o == 1'b1 && msg_valid_o == 2'b00 && mem_rd_en_o == 1'b0, "R1 in reset",
        {req_ready_o, msg_valid_o, mem_rd_en_o}, 4'b1000);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1'b1 && msg_valid_o == 2'b00 && mem_rd_en_o == 1'b0, "R1 after reset",
        {req_ready_o, msg_valid_o, mem_rd_en_o}, 4'b1000);
    do_req(0, 1, 0, "R1");      // fresh block answered from memory
    do_req(0, 3, 0, "R8");      // second sharer kept
    do_req(1, 2, 0, "R5");      // invalidates nodes 1 and 3
    do_req(0, 0, 0, "R3");      // forward to owner 2
    do_req(1, 1, 0, "R4");      // invalidates 0 and 2
    do_req(1, 1, 0, "R7");      // owner re-requests
    do_req(0, 1, 0, "R2");      // owner reads own block
    do_req(0, 0, 5, "R8");
    do_req(0, 1, 5, "R8");
    do_req(0, 2, 5, "R8");
    do_req(1, 3, 5, "R6");      // three invalidates
    for (int k = 0; k < 400; k++)
      do_req(($urandom % 3) == 0, int'($urandom % 4), int'($urandom % 8), "rand");
    @(negedge clk);
    finish_run();
  end
endmodule